// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular receive area of an on-chip packet RAM. The RAM is split into 256-byte pages. The page number forms the high byte of a 16-bit RAM address, and the offset inside the page forms the low byte. Frames arrive already accepted, as a byte stream with a last-byte marker. The block writes each frame into the ring starting at the current page. Payload bytes go in from offset 4 onward. Once the frame length is known, a four-byte descriptor is written at offsets 0 to 3 of the first page.

The ring is bounded by four host-visible page registers:
- a lower page limit (first page of the ring),
- an upper page limit (one past the last page of the ring),
- a write page (next free page),
- a release page (oldest page the host has not yet read).

When the write page equals the release page, the ring holds no unread frames. The block never lets a frame take the release page, so it never makes a full ring look empty. A frame that would need that page is discarded and flagged. After a good frame, the write page moves to the page after the frame and a receive flag is raised. The host reads a frame, writes the descriptor's next-page value into the release register, and clears the flags by writing ones to them.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the lower limit is 0x4C, the upper limit is 0x80, the write page and the release page are both 0x4C, the status byte is 0x00 and `in_ready` is 1.
- R2: A host write with `cfg_we` high loads `cfg_data` into the register picked by `cfg_sel` (0 lower limit, 1 upper limit, 2 write page, 3 release page). The new value is visible on the matching output one cycle later.
- R3: Payload byte k of a frame (counting from 0) is written to RAM address write_page*256 + 4 + k. When a page is full, writing continues at offset 0 of the following page. Bytes are written in arrival order.
- R4: The page that follows page p is p+1, except that the page following (upper limit - 1) is the lower limit.
- R5: After the last payload byte, the descriptor is written to offsets 0, 1, 2 and 3 of the frame's first page, in that order. Offset 0 holds the next page, offset 1 holds the status code 0x01, offset 2 holds the length low byte and offset 3 holds the length high byte. The length is the payload byte count plus 4.
- R6: The next page is the page that follows the page holding the last payload byte. `in_ready` is 0 during the four descriptor cycles. At their end the write page takes the next-page value.
- R7: A frame that is stored completely sets status bit 0.
- R8: A frame is discarded if either of these equals the release page: a page the frame would move into, or the frame's next page. A discarded frame gets no descriptor and leaves the write page unchanged. Status bit 4 is set. The rest of the frame is accepted and thrown away. Payload bytes written before the discard decision stay in RAM.
- R9: A write with `sts_clr` high clears the status bits that are 1 in `sts_clr_mask` and leaves every other bit as it was.
- R10: Moving the release page forward lets a frame that was discarded before be stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_we | input | 1 | Host page-register write strobe |
| cfg_sel | input | 2 | Register select: 0 lower, 1 upper, 2 write page, 3 release page |
| cfg_data | input | 8 | Page value to write |
| sts_clr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 8 | Bits to clear |
| ring_lo | output | 8 | Lower page limit |
| ring_hi | output | 8 | Upper page limit (exclusive) |
| wr_page | output | 8 | Next free page |
| rel_page | output | 8 | Oldest unread page |
| status | output | 8 | Bit 0 frame stored, bit 4 frame discarded |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte address, page in the high byte |
| ram_wdata | output | 8 | RAM write data |

## Verification
The bench checks several boundary cases:
- A frame whose payload exactly fills its first page. A design that rounds wrongly would put the next page two pages ahead, or would leave it on the frame's own page.
- A frame that runs past the upper limit. A design that wraps wrongly would write outside the ring.
- Two discard cases: one where the release page is hit at a page crossing in mid-frame, and one where it is hit only by the next-page value. A design that gets either wrong would write a descriptor, or would move the write page onto the release page so that the ring looks empty.
- A frame stored after the host frees space, and flag clears that touch only some bits. A design that gets these wrong would keep refusing frames after space is freed, or would clear a flag that was not selected.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DROP, ST_HDR} rxr_state_e;

  localparam int HDR_BYTES   = 4;
  localparam int LEN_W       = 16;
  localparam int STS_W       = 8;
  localparam int STS_RX_BIT  = 0;
  localparam int STS_OVF_BIT = 4;
  localparam int NUM_PREGS   = 4;

  localparam logic [1:0] SEL_LO  = 2'd0;
  localparam logic [1:0] SEL_HI  = 2'd1;
  localparam logic [1:0] SEL_WR  = 2'd2;
  localparam logic [1:0] SEL_REL = 2'd3;
endpackage

// File: rtl/rxr_page_regs.sv
module rxr_page_regs
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] RST_LO = 8'h4C,
  parameter logic [PAGE_W-1:0] RST_HI = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_data,
  input  logic              wr_upd,
  input  logic [PAGE_W-1:0] wr_new,
  output logic [PAGE_W-1:0] ring_lo,
  output logic [PAGE_W-1:0] ring_hi,
  output logic [PAGE_W-1:0] wr_page,
  output logic [PAGE_W-1:0] rel_page
);
  logic [NUM_PREGS-1:0][PAGE_W-1:0] preg_q;
  logic [NUM_PREGS-1:0][PAGE_W-1:0] preg_d;
  logic [NUM_PREGS-1:0]             preg_en;

  for (genvar i = 0; i < NUM_PREGS; i++) begin : g_preg
    localparam logic [PAGE_W-1:0] RST_V = (i == int'(SEL_HI)) ? RST_HI : RST_LO;
    localparam logic [1:0]        MY_SEL = 2'(i);

    always_comb begin
      preg_en[i] = 1'b0;
      preg_d[i]  = preg_q[i];
      if (cfg_we && cfg_sel == MY_SEL) begin
        preg_en[i] = 1'b1;
        preg_d[i]  = cfg_data;
      end else if (MY_SEL == SEL_WR && wr_upd) begin
        preg_en[i] = 1'b1;
        preg_d[i]  = wr_new;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          preg_q[i] <= RST_V;
      else if (preg_en[i]) preg_q[i] <= preg_d[i];
    end
  end

  assign ring_lo  = preg_q[SEL_LO];
  assign ring_hi  = preg_q[SEL_HI];
  assign wr_page  = preg_q[SEL_WR];
  assign rel_page = preg_q[SEL_REL];
endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_rx,
  input  logic             set_ovf,
  input  logic             clr,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] sts
);
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] sts_d;
  logic             sts_en;

  always_comb begin
    set_vec              = '0;
    set_vec[STS_RX_BIT]  = set_rx;
    set_vec[STS_OVF_BIT] = set_ovf;
    sts_en = clr || set_rx || set_ovf;
    sts_d  = (sts_q & ~(clr ? clr_mask : '0)) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts = sts_q;

  // R9
  clr_only_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_rx && !set_ovf) |=> (sts_q == ($past(sts_q) & ~$past(clr_mask))));
endmodule

// File: rtl/rxr_wr_ctrl.sv
module rxr_wr_ctrl
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter logic [7:0] OK_CODE = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic                     in_last,
  output logic                     in_ready,
  input  logic [PAGE_W-1:0]        ring_lo,
  input  logic [PAGE_W-1:0]        ring_hi,
  input  logic [PAGE_W-1:0]        wr_page,
  input  logic [PAGE_W-1:0]        rel_page,
  output logic                     wr_upd,
  output logic [PAGE_W-1:0]        wr_new,
  output logic                     set_rx,
  output logic                     set_ovf,
  output logic                     ram_we,
  output logic [PAGE_W+OFF_W-1:0]  ram_addr,
  output logic [7:0]               ram_wdata
);
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int HC_W   = $clog2(HDR_BYTES);
  localparam logic [OFF_W-1:0] OFF_END   = '1;
  localparam logic [OFF_W-1:0] OFF_FIRST = OFF_W'(HDR_BYTES);
  localparam logic [HC_W-1:0]  HC_END    = HC_W'(HDR_BYTES - 1);

  function automatic logic [PAGE_W-1:0] follow(input logic [PAGE_W-1:0] p,
                                              input logic [PAGE_W-1:0] lo,
                                              input logic [PAGE_W-1:0] hi);
    logic [PAGE_W-1:0] inc;
    inc = p + 1'b1;
    return (inc == hi) ? lo : inc;
  endfunction

  rxr_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d, nxt_q, nxt_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic              we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        wdata_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  logic [PAGE_W-1:0] eff_page, step_page;
  logic [OFF_W-1:0]  eff_off;
  logic [LEN_W-1:0]  eff_len;
  logic              take;

  assign in_ready = (state_q != ST_HDR);

  always_comb begin
    eff_page  = (state_q == ST_IDLE) ? wr_page   : page_q;
    eff_off   = (state_q == ST_IDLE) ? OFF_FIRST : off_q;
    eff_len   = (state_q == ST_IDLE) ? LEN_W'(HDR_BYTES) : len_q;
    step_page = follow(eff_page, ring_lo, ring_hi);
    take      = in_valid && in_ready;

    state_d = state_q;
    page_d  = page_q;
    off_d   = off_q;
    len_d   = len_q;
    nxt_d   = nxt_q;
    hc_d    = hc_q;
    we_d    = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    wr_upd  = 1'b0;
    wr_new  = nxt_q;
    set_rx  = 1'b0;
    set_ovf = 1'b0;

    case (state_q)
      ST_IDLE, ST_RECV: begin
        if (take) begin
          we_d    = 1'b1;
          addr_d  = {eff_page, eff_off};
          wdata_d = in_data;
          len_d   = eff_len + 1'b1;
          off_d   = eff_off + 1'b1;
          page_d  = eff_page;
          state_d = ST_RECV;
          if (in_last) begin
            if (step_page == rel_page) begin
              set_ovf = 1'b1;
              state_d = ST_IDLE;
            end else begin
              nxt_d   = step_page;
              hc_d    = '0;
              state_d = ST_HDR;
            end
          end else if (eff_off == OFF_END) begin
            page_d = step_page;
            if (step_page == rel_page) begin
              set_ovf = 1'b1;
              state_d = ST_DROP;
            end
          end
        end
      end
      ST_DROP: begin
        if (take && in_last) state_d = ST_IDLE;
      end
      ST_HDR: begin
        we_d   = 1'b1;
        addr_d = {wr_page, OFF_W'(hc_q)};
        case (hc_q)
          2'd0:    wdata_d = 8'(nxt_q);
          2'd1:    wdata_d = OK_CODE;
          2'd2:    wdata_d = len_q[7:0];
          default: wdata_d = len_q[15:8];
        endcase
        hc_d = hc_q + 1'b1;
        if (hc_q == HC_END) begin
          wr_upd  = 1'b1;
          set_rx  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      nxt_q   <= '0;
      hc_q    <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      off_q   <= off_d;
      len_q   <= len_d;
      nxt_q   <= nxt_d;
      hc_q    <= hc_d;
      we_q    <= we_d;
      if (we_d) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;

  // R6
  ready_drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_last));

  // R4
  ram_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[ADDR_W-1:OFF_W] >= ring_lo && ram_addr[ADDR_W-1:OFF_W] < ring_hi));
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter logic [PAGE_W-1:0] RST_LO = 8'h4C,
  parameter logic [PAGE_W-1:0] RST_HI = 8'h80,
  parameter logic [7:0] OK_CODE = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  input  logic                    in_last,
  output logic                    in_ready,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [PAGE_W-1:0]       cfg_data,
  input  logic                    sts_clr,
  input  logic [STS_W-1:0]        sts_clr_mask,
  output logic [PAGE_W-1:0]       ring_lo,
  output logic [PAGE_W-1:0]       ring_hi,
  output logic [PAGE_W-1:0]       wr_page,
  output logic [PAGE_W-1:0]       rel_page,
  output logic [STS_W-1:0]        status,
  output logic                    ram_we,
  output logic [PAGE_W+OFF_W-1:0] ram_addr,
  output logic [7:0]              ram_wdata
);
  logic              wr_upd;
  logic [PAGE_W-1:0] wr_new;
  logic              set_rx, set_ovf;

  rxr_page_regs #(.PAGE_W(PAGE_W), .RST_LO(RST_LO), .RST_HI(RST_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .wr_upd(wr_upd), .wr_new(wr_new), .ring_lo(ring_lo), .ring_hi(ring_hi),
    .wr_page(wr_page), .rel_page(rel_page));

  rxr_wr_ctrl #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .OK_CODE(OK_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .ring_lo(ring_lo), .ring_hi(ring_hi), .wr_page(wr_page),
    .rel_page(rel_page), .wr_upd(wr_upd), .wr_new(wr_new), .set_rx(set_rx),
    .set_ovf(set_ovf), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  rxr_status u_sts (
    .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_ovf(set_ovf),
    .clr(sts_clr), .clr_mask(sts_clr_mask), .sts(status));

  // R6
  wr_moves_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wr_page) && !$past(cfg_we)) |-> status[STS_RX_BIT]);

  // R8
  drop_keeps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[STS_OVF_BIT]) && !$past(cfg_we)) |-> $stable(wr_page));

  // R8
  never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd && !cfg_we) |=> (wr_page != rel_page));
endmodule

// File: tb/rx_page_ring_tb.sv
module rx_page_ring_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        sts_clr = 1'b0;
  logic [7:0]  sts_clr_mask = '0;
  logic [7:0]  ring_lo, ring_hi, wr_page, rel_page, status;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct packed { logic [15:0] addr; logic [7:0] data; logic hdr; } wr_item_t;
  wr_item_t exp_q[$];

  logic [7:0] m_lo = 8'h4C, m_hi = 8'h80, m_wr = 8'h4C, m_rel = 8'h4C;

  always #2 clk = ~clk;

  rx_page_ring u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .ring_lo(ring_lo), .ring_hi(ring_hi),
    .wr_page(wr_page), .rel_page(rel_page), .status(status), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected RAM writes in order
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: actual write 0x%0h<=0x%0h expected none", ram_addr, ram_wdata);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (ram_addr !== e.addr || ram_wdata !== e.data) begin
          errors++;
          $display("FAIL %s: actual 0x%0h<=0x%0h expected 0x%0h<=0x%0h",
                   e.hdr ? "R5" : "R3", ram_addr, ram_wdata, e.addr, e.data);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] follow_m(input logic [7:0] p);
    logic [7:0] inc;
    inc = p + 8'd1;
    return (inc == m_hi) ? m_lo : inc;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_lo = v;
      2'd1: m_hi = v;
      2'd2: m_wr = v;
      default: m_rel = v;
    endcase
  endtask

  task automatic clear_sts(input logic [7:0] m);
    @(negedge clk);
    sts_clr = 1'b1; sts_clr_mask = m;
    @(negedge clk);
    sts_clr = 1'b0; sts_clr_mask = '0;
  endtask

  // driver: predicts writes, drives the frame, checks write page and status
  task automatic send_frame(input int n, input logic [7:0] seed, input string req);
    logic [7:0]  pg, first, np;
    logic [7:0]  off;
    logic [15:0] len;
    bit          dropped, ovf;
    first = m_wr; pg = m_wr; off = 8'd4; len = 16'd4; dropped = 0; ovf = 0; np = m_wr;
    for (int k = 0; k < n; k++) begin
      if (!dropped) begin
        exp_q.push_back('{addr: {pg, off}, data: 8'(seed + 8'(k * 7)), hdr: 1'b0});
        len++;
        if (k == n - 1) begin
          np = follow_m(pg);
          if (np == m_rel) ovf = 1;
        end else if (off == 8'hFF) begin
          pg = follow_m(pg);
          off = 8'd0;
          if (pg == m_rel) begin dropped = 1; ovf = 1; end
        end else off++;
      end
    end
    if (!ovf) begin
      exp_q.push_back('{addr: {first, 8'd0}, data: np, hdr: 1'b1});
      exp_q.push_back('{addr: {first, 8'd1}, data: 8'h01, hdr: 1'b1});
      exp_q.push_back('{addr: {first, 8'd2}, data: len[7:0], hdr: 1'b1});
      exp_q.push_back('{addr: {first, 8'd3}, data: len[15:8], hdr: 1'b1});
    end
    clear_sts(8'hFF);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = 8'(seed + 8'(k * 7)); in_last = (k == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check({req, " pending writes"}, 16'(exp_q.size()), 16'd0);
    if (!ovf) m_wr = np;
    check({req, " write page"}, {8'd0, wr_page}, {8'd0, m_wr});
    check({req, " status"}, {8'd0, status}, ovf ? 16'h0010 : 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 lo", {8'd0, ring_lo}, 16'h004C);
    check("R1 hi", {8'd0, ring_hi}, 16'h0080);
    check("R1 wr", {8'd0, wr_page}, 16'h004C);
    check("R1 rel", {8'd0, rel_page}, 16'h004C);
    check("R1 status", {8'd0, status}, 16'h0000);
    check("R1 ready", {15'd0, in_ready}, 16'h0001);

    // R3 R5 R6 R7: short frame
    send_frame(60, 8'h11, "R7 short");
    // R9: clear only unselected bit, then selected bit
    @(negedge clk); sts_clr = 1'b1; sts_clr_mask = 8'h10;
    @(negedge clk); sts_clr = 1'b0;
    check("R9 keep bit0", {8'd0, status}, 16'h0001);
    @(negedge clk); sts_clr = 1'b1; sts_clr_mask = 8'h01;
    @(negedge clk); sts_clr = 1'b0;
    check("R9 clear bit0", {8'd0, status}, 16'h0000);

    // R6 exact page fill, then multi-page frame
    send_frame(252, 8'h20, "R6 exact page");
    send_frame(600, 8'h33, "R6 multi page");

    // R2 reprogram a small ring, R4 wrap across the upper limit
    cfg_write(2'd0, 8'h10);
    cfg_write(2'd1, 8'h14);
    cfg_write(2'd2, 8'h13);
    cfg_write(2'd3, 8'h12);
    check("R2 lo", {8'd0, ring_lo}, 16'h0010);
    check("R2 hi", {8'd0, ring_hi}, 16'h0014);
    check("R2 wr", {8'd0, wr_page}, 16'h0013);
    check("R2 rel", {8'd0, rel_page}, 16'h0012);
    send_frame(300, 8'h44, "R4 wrap");

    // R8 discard at page crossing, then discard on next page
    send_frame(300, 8'h55, "R8 crossing");
    send_frame(100, 8'h66, "R8 next page");

    // R10 free space and retry
    cfg_write(2'd3, 8'h13);
    send_frame(100, 8'h77, "R10 after release");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule